// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This peripheral holds four independent down-counters, each up to 32 bits wide, behind a plain register bus. Each channel has its own control word, immediate load value and deferred reload value. Software starts a countdown by writing a value. Elapsed time is the negated value it reads back. A counter can run periodically, taking its reload value from the deferred register each time it passes zero, or it can stop at zero in one-shot mode. Each channel's counting rate is either the bus clock or one sixteenth of it.

Each channel has a pending bit that is set when its count steps down to zero. All pending bits share one mask register and one write-one-to-clear register. The masked bits are ORed together onto a single interrupt line. A typical setup uses one channel as a free-running time base, with zero in both load registers, and another as a one-shot event timer.

Top module: `dct_timer`

## Requirements
- R1: After reset, every count reads 0xFFFFFFFF. Every control word, every deferred reload value, the mask and the pending bits read 0, and `irq_o` is low.
- R2: Address map. The shared page at 0x00 holds the mask at 0x00, pending (raw) at 0x04, masked pending at 0x08 and clear at 0x0C. Clear reads as 0. Channel n sits at 0x10·(n+1): load at +0x0, live count at +0x4 (read-only), control at +0x8, deferred reload at +0xC. A write reaches at most one register.
- R3: A write to a channel's load register sets its count on that clock edge, whether or not the channel is enabled. The value is truncated to 16 bits when the wide bit is 0. The write takes priority over a count step on the same edge, so writing an enabled one-shot channel starts a new countdown.
- R4: A channel whose enable bit (control bit 0) is 0 keeps its count.
- R5: Control bit 3 selects the rate. At 0 an enabled channel steps down on every edge after the enabling edge. At 1 it steps once every 16 edges, first on the 16th edge after enabling. Clearing the enable bit restarts this divider.
- R6: In periodic mode (control bit 1 = 0), a step taken at count 0 loads the deferred value minus one. A deferred value of 0 therefore wraps to the largest count.
- R7: In one-shot mode (control bit 1 = 1), the count stops at 0 and stays there until the load register is written.
- R8: A step from a nonzero count to 0 sets pending bit n for channel n. Writing 1 to bit n of the clear register clears that bit. Writing 0 leaves it alone.
- R9: Masked pending equals pending AND mask, and `irq_o` is high exactly when any masked bit is 1.
- R10: With control bit 2 (wide) at 0, counting is confined to 16 bits, so a wrap lands on 0xFFFF. With wide at 1 the full 32 bits are used.
- R11: Writing the deferred reload register does not change the current count. The new value is used at the next pass through zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | OR of all masked pending bits |

## Verification
The counters are tried with several patterns, and each one separates a different fault:
- A one-shot countdown sampled on every edge separates stopping at zero from wrapping.
- A periodic run whose deferred value is rewritten mid-period separates an immediate reload from a deferred one.
- Zero in both load registers, at both widths, exposes an off-by-one in the reload and a wrong wrap width.
- A divide-by-16 run sampled on every edge across three steps, then repeated after a disable, pins the position of the first step and the restart of the divider.
- A sweep of all 16 mask values against a fixed pending pattern, followed by partial clears, separates the mask gating from the write-one-to-clear behaviour.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned CNT_W  = 32;
    localparam int unsigned HALF_W = CNT_W / 2;

    // Control word layout: bit0 enable, bit1 one-shot, bit2 wide, bit3 slow rate
    typedef struct packed {
        logic slow;
        logic wide;
        logic oneshot;
        logic en;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    // Offsets inside the shared page
    typedef enum logic [3:0] {
        SH_MASK = 4'h0,
        SH_RAW  = 4'h4,
        SH_MIS  = 4'h8,
        SH_CLR  = 4'hC
    } sh_ofs_e;

    // Offsets inside a channel page
    typedef enum logic [3:0] {
        CH_LOAD = 4'h0,
        CH_VAL  = 4'h4,
        CH_CTRL = 4'h8,
        CH_BG   = 4'hC
    } ch_ofs_e;

    function automatic logic [CNT_W-1:0] span_mask(input logic wide);
        return wide ? {CNT_W{1'b1}} : {{(CNT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    endfunction

    // Count after a step from zero in periodic mode
    function automatic logic [CNT_W-1:0] wrap_value(input logic [CNT_W-1:0] bg,
                                                     input logic wide);
        return (bg - {{(CNT_W-1){1'b0}}, 1'b1}) & span_mask(wide);
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned PS_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic slow,
    output logic tick
);
    logic [PS_W-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    assign tick = en && (!slow || (&pcnt));

    // A slow tick is never followed at once by another slow tick
    assert_slow_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && slow) |=> !(tick && slow))
        else $error("slow tick repeated on consecutive edges");

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int unsigned PS_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_we,
    input  logic             ctl_we,
    input  logic             bg_we,
    input  logic [CNT_W-1:0] wdata,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] bg,
    output logic             hit
);
    logic             tick;
    logic [CNT_W-1:0] cnt_nxt;

    tmr_prescaler #(.PS_W(PS_W)) u_ps (
        .clk  (clk),
        .rst  (rst),
        .en   (ctrl.en),
        .slow (ctrl.slow),
        .tick (tick)
    );

    always_comb begin
        if (cnt == '0) begin
            cnt_nxt = ctrl.oneshot ? '0 : wrap_value(bg, ctrl.wide);
        end else begin
            cnt_nxt = (cnt - 1'b1) & span_mask(ctrl.wide);
        end
    end

    assign hit = tick && !ld_we && (cnt != '0) && (cnt_nxt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            cnt  <= '1;
            bg   <= '0;
        end else begin
            if (ctl_we) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (bg_we)  bg   <= wdata;
            if (ld_we) begin
                cnt <= wdata & span_mask(ctrl.wide);
            end else if (tick) begin
                cnt <= cnt_nxt;
            end
        end
    end

    assert_load_now_R3: assert property (@(posedge clk) disable iff (rst)
        (ld_we && ctrl.wide) |=> (cnt == $past(wdata)))
        else $error("load write did not set the count");

    assert_hold_off_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en && !ld_we) |=> $stable(cnt))
        else $error("disabled channel changed its count");

    assert_periodic_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld_we && !ctrl.oneshot && ctrl.wide && cnt == '0)
            |=> ((cnt + 1'b1) == $past(bg)))
        else $error("periodic reload value wrong");

    assert_oneshot_park_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && ctrl.oneshot && cnt == '0 && !ld_we) |=> (cnt == '0))
        else $error("one-shot channel left zero");

    assert_bg_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (bg_we && !ld_we && !tick) |=> $stable(cnt))
        else $error("deferred reload write disturbed the count");

endmodule

// File: rtl/tmr_irq_agg.sv
module tmr_irq_agg #(
    parameter int unsigned N_CH = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mask_we,
    input  logic            clr_we,
    input  logic [N_CH-1:0] wdata,
    input  logic [N_CH-1:0] hit,
    output logic [N_CH-1:0] mask,
    output logic [N_CH-1:0] raw,
    output logic [N_CH-1:0] masked,
    output logic            irq
);
    logic [N_CH-1:0] clr_bits;

    assign clr_bits = clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
            raw  <= '0;
        end else begin
            if (mask_we) mask <= wdata;
            raw <= (raw & ~clr_bits) | hit;
        end
    end

    assign masked = raw & mask;
    assign irq    = |masked;

    assert_event_sets_R8: assert property (@(posedge clk) disable iff (rst)
        (|hit) |=> ((raw & $past(hit)) == $past(hit)))
        else $error("zero event did not set pending bit");

    assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((raw & $past(wdata) & ~$past(hit)) == '0))
        else $error("clear did not drop pending bit");

endmodule

// File: rtl/dct_timer.sv
module dct_timer
    import tmr_pkg::*;
#(
    parameter int unsigned N_CH = 4,
    parameter int unsigned AW   = 8,
    parameter int unsigned PS_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq_o
);
    localparam int unsigned PG_W  = AW - 4;
    localparam int unsigned NSTRB = 3 * N_CH + 2;

    logic [PG_W-1:0] page;
    logic [3:0]      ofs;
    logic            sh_page;

    assign page    = bus_addr[AW-1:4];
    assign ofs     = bus_addr[3:0];
    assign sh_page = (page == '0);

    logic             mask_we, clr_we;
    logic [N_CH-1:0]  hit, mask, raw, masked;
    logic [NSTRB-1:0] strobes;

    ctrl_t            ch_ctl [N_CH];
    logic [CNT_W-1:0] ch_cnt [N_CH];
    logic [CNT_W-1:0] ch_bg  [N_CH];

    assign mask_we = bus_wr && sh_page && (ofs == SH_MASK);
    assign clr_we  = bus_wr && sh_page && (ofs == SH_CLR);
    assign strobes[1:0] = {clr_we, mask_we};

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic sel, ld_we, ctl_we, bg_we;

        assign sel    = bus_wr && (page == PG_W'(i + 1));
        assign ld_we  = sel && (ofs == CH_LOAD);
        assign ctl_we = sel && (ofs == CH_CTRL);
        assign bg_we  = sel && (ofs == CH_BG);
        assign strobes[2 + 3*i +: 3] = {bg_we, ctl_we, ld_we};

        tmr_channel #(.PS_W(PS_W)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .ld_we  (ld_we),
            .ctl_we (ctl_we),
            .bg_we  (bg_we),
            .wdata  (bus_wdata),
            .ctrl   (ch_ctl[i]),
            .cnt    (ch_cnt[i]),
            .bg     (ch_bg[i]),
            .hit    (hit[i])
        );
    end

    tmr_irq_agg #(.N_CH(N_CH)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .mask_we (mask_we),
        .clr_we  (clr_we),
        .wdata   (bus_wdata[N_CH-1:0]),
        .hit     (hit),
        .mask    (mask),
        .raw     (raw),
        .masked  (masked),
        .irq     (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (sh_page) begin
            case (ofs)
                SH_MASK: bus_rdata = {{(CNT_W-N_CH){1'b0}}, mask};
                SH_RAW:  bus_rdata = {{(CNT_W-N_CH){1'b0}}, raw};
                SH_MIS:  bus_rdata = {{(CNT_W-N_CH){1'b0}}, masked};
                default: bus_rdata = '0;
            endcase
        end
        for (int i = 0; i < N_CH; i++) begin
            if (page == PG_W'(i + 1)) begin
                case (ofs)
                    CH_LOAD: bus_rdata = ch_cnt[i];
                    CH_VAL:  bus_rdata = ch_cnt[i];
                    CH_CTRL: bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ch_ctl[i]};
                    CH_BG:   bus_rdata = ch_bg[i];
                    default: bus_rdata = '0;
                endcase
            end
        end
    end

    assert_single_target_R2: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> $onehot0(strobes))
        else $error("one write reached several registers");

    assert_irq_needs_mask_R9: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq_o)
        else $error("interrupt raised with all channels masked");

endmodule

// File: tb/tb_dct_timer.sv
module tb_dct_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [7:0] A_MASK = 8'h00, A_RAW = 8'h04, A_MIS = 8'h08, A_CLR = 8'h0C;
    localparam logic [3:0] O_LOAD = 4'h0, O_VAL = 4'h4, O_CTRL = 4'h8, O_BG = 4'hC;
    // control word bits: 0 enable, 1 one-shot, 2 wide, 3 slow
    localparam logic [31:0] C_EN = 32'h1, C_OS = 32'h2, C_WIDE = 32'h4, C_SLOW = 32'h8;

    dct_timer dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] ca(input int ch, input logic [3:0] o);
        return 8'((ch + 1) * 16) | {4'h0, o};
    endfunction

    function automatic logic [31:0] oneshot_exp(input int k, input longint l);
        return (longint'(k) <= l) ? 32'(l - k) : 32'h0;
    endfunction

    function automatic logic [31:0] periodic_exp(input int k, input longint l,
                                                 input longint b, input longint m);
        longint p;
        p = (b == 0) ? m : b;
        if (longint'(k) <= l) return 32'(l - k);
        return 32'((p - 1) - ((longint'(k) - l - 1) % p));
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'h1, 32'h0);
        summary();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pat;

        @(negedge clk);
        step(3);
        rst = 1'b0;

        // R1 R2: reset values through the map
        for (int ch = 0; ch < 4; ch++) begin
            rd(ca(ch, O_VAL), v);  check("R1 count after reset", v, 32'hFFFF_FFFF);
            rd(ca(ch, O_CTRL), v); check("R1 control after reset", v, 32'h0);
            rd(ca(ch, O_BG), v);   check("R1 deferred after reset", v, 32'h0);
        end
        rd(A_MASK, v); check("R1 mask after reset", v, 0);
        rd(A_RAW, v);  check("R1 raw after reset", v, 0);
        rd(A_MIS, v);  check("R2 masked after reset", v, 0);
        rd(A_CLR, v);  check("R2 clear reads zero", v, 0);
        check("R1 irq after reset", {31'h0, irq_o}, 0);

        // R3 R4 R10 R2: loads into stopped channels, each at its own page
        for (int ch = 0; ch < 4; ch++) begin
            pat = 32'hA5A5_0007 + 32'(ch * 32'h0011_1111);
            wr(ca(ch, O_CTRL), C_WIDE);
            wr(ca(ch, O_LOAD), pat);
            rd(ca(ch, O_VAL), v); check("R3 load sets count", v, pat);
            rd(ca(ch, O_CTRL), v); check("R2 control readback", v, C_WIDE);
            step(5);
            rd(ca(ch, O_VAL), v); check("R4 stopped count holds", v, pat);
        end
        for (int ch = 0; ch < 4; ch++) begin
            rd(ca(ch, O_VAL), v);
            check("R2 channel pages independent", v, 32'hA5A5_0007 + 32'(ch * 32'h0011_1111));
        end
        wr(ca(1, O_CTRL), 32'h0);
        wr(ca(1, O_LOAD), 32'h1234_5678);
        rd(ca(1, O_VAL), v); check("R10 narrow load truncated", v, 32'h0000_5678);

        // R7 R8 R5: one-shot at full rate on channel 0
        wr(A_CLR, 32'hF);
        wr(ca(0, O_CTRL), C_WIDE | C_OS);
        wr(ca(0, O_LOAD), 32'd5);
        wr(ca(0, O_CTRL), C_WIDE | C_OS | C_EN);
        for (int k = 0; k <= 8; k++) begin
            rd(ca(0, O_VAL), v); check("R7 one-shot countdown", v, oneshot_exp(k, 5));
            rd(A_RAW, v); check("R8 pending on reaching zero", v & 32'h1, (k >= 5) ? 32'h1 : 32'h0);
            step(1);
        end
        wr(A_CLR, 32'h1);
        rd(A_RAW, v); check("R8 clear drops bit", v & 32'h1, 0);
        wr(ca(0, O_LOAD), 32'd3);
        for (int k = 0; k <= 5; k++) begin
            rd(ca(0, O_VAL), v); check("R7 reload restarts one-shot", v, oneshot_exp(k, 3));
            step(1);
        end
        wr(ca(0, O_CTRL), C_WIDE | C_OS);

        // R6 R11: periodic on channel 1, deferred value rewritten mid-run
        wr(ca(1, O_CTRL), C_WIDE);
        wr(ca(1, O_LOAD), 32'd2);
        wr(ca(1, O_BG), 32'd4);
        wr(ca(1, O_CTRL), C_WIDE | C_EN);
        for (int k = 0; k < 3; k++) begin
            rd(ca(1, O_VAL), v); check("R6 periodic first lap", v, periodic_exp(k, 2, 4, 64'h1_0000_0000));
            step(1);
        end
        rd(ca(1, O_VAL), v); check("R6 reload uses deferred minus one", v, 32'd3);
        wr(ca(1, O_BG), 32'd7);
        for (int k = 0; k <= 10; k++) begin
            rd(ca(1, O_VAL), v); check("R11 deferred write waits for zero", v, periodic_exp(k, 2, 7, 64'h1_0000_0000));
            step(1);
        end
        wr(ca(1, O_CTRL), C_WIDE);

        // R6 R10: zero deferred value wraps across the full width
        wr(ca(3, O_CTRL), C_WIDE);
        wr(ca(3, O_LOAD), 32'd1);
        wr(ca(3, O_BG), 32'd0);
        wr(ca(3, O_CTRL), C_WIDE | C_EN);
        for (int k = 0; k <= 3; k++) begin
            rd(ca(3, O_VAL), v); check("R6 wide free-run wrap", v, periodic_exp(k, 1, 0, 64'h1_0000_0000));
            step(1);
        end
        wr(ca(3, O_CTRL), 32'h0);
        wr(ca(3, O_LOAD), 32'd1);
        wr(ca(3, O_CTRL), C_EN);
        for (int k = 0; k <= 3; k++) begin
            rd(ca(3, O_VAL), v); check("R10 narrow free-run wrap", v, periodic_exp(k, 1, 0, 64'h1_0000));
            step(1);
        end
        wr(ca(3, O_CTRL), 32'h0);

        // R5: divide-by-16 on channel 2, then divider restart after disable
        wr(ca(2, O_CTRL), C_SLOW | C_WIDE | C_OS);
        wr(ca(2, O_LOAD), 32'd3);
        wr(ca(2, O_CTRL), C_SLOW | C_WIDE | C_OS | C_EN);
        for (int k = 0; k <= 50; k++) begin
            rd(ca(2, O_VAL), v); check("R5 slow rate step", v, oneshot_exp(k / 16, 3));
            step(1);
        end
        wr(ca(2, O_CTRL), C_SLOW | C_WIDE | C_OS);
        wr(ca(2, O_LOAD), 32'd3);
        step(7);
        wr(ca(2, O_CTRL), C_SLOW | C_WIDE | C_OS | C_EN);
        for (int k = 0; k <= 20; k++) begin
            rd(ca(2, O_VAL), v); check("R5 divider restarts", v, oneshot_exp(k / 16, 3));
            step(1);
        end
        wr(ca(2, O_CTRL), 32'h0);

        // R8 R9: known pending pattern, mask sweep, partial clears
        wr(A_CLR, 32'hF);
        rd(A_RAW, v); check("R8 all cleared", v, 0);
        wr(ca(0, O_LOAD), 32'd2);
        wr(ca(0, O_CTRL), C_WIDE | C_OS | C_EN);
        wr(ca(3, O_LOAD), 32'd2);
        wr(ca(3, O_CTRL), C_WIDE | C_OS | C_EN);
        step(3);
        rd(A_RAW, v); check("R8 two channels pending", v, 32'h9);
        for (int m = 0; m < 16; m++) begin
            wr(A_MASK, 32'(m));
            rd(A_MIS, v); check("R9 masked status", v, 32'(m) & 32'h9);
            check("R9 irq line", {31'h0, irq_o}, ((m & 9) != 0) ? 32'h1 : 32'h0);
        end
        wr(A_CLR, 32'h1);
        rd(A_RAW, v); check("R8 clear one bit", v, 32'h8);
        wr(A_CLR, 32'h6);
        rd(A_RAW, v); check("R8 clear of idle bits", v, 32'h8);
        check("R9 irq still high", {31'h0, irq_o}, 32'h1);
        wr(A_CLR, 32'h8);
        rd(A_RAW, v); check("R8 last bit cleared", v, 0);
        check("R9 irq low when none pending", {31'h0, irq_o}, 0);

        summary();
    end

endmodule